// File: doc/BRIEF.md
# Transmit Cell Buffer with Start-of-Cell Realignment

This block sits between the transmit side of a cell bus (the poll-and-select interface that an ATM layer drives toward a PHY) and the line-side logic that serialises cells. Each accepted transfer writes one byte. A marker flags the first byte of each 53-byte cell. The buffer stores only whole cells. A cell becomes visible on the read side once its last byte has been written. The read side hands cells out in arrival order as a valid/ready byte stream and marks byte 0 of each cell.

A run-time input sets the usable capacity to 2, 3 or 4 cells. Two room indications tell the poll logic whether one free cell slot, or two, remain. A cell that is still being filled already counts as occupying a slot. A start marker that arrives part way through a cell throws away the partial cell, and writing restarts from that byte. A start marker that finds no free slot is refused, and a sticky overflow flag is raised.

Top module: `utx_cell_buffer`

## Requirements
- R1: After reset, `out_valid` is 0, `overflow_seen` is 0, and both `room_1` and `room_2` are 1.
- R2: A cell becomes readable only in the cycle after its 53rd byte is accepted. Until then `out_valid` stays 0 for that cell.
- R3: A byte with `in_soc`=1 that arrives while a cell is partly written discards the bytes already written. It becomes byte 0 of a fresh cell in the same slot.
- R4: Bytes with `in_soc`=0 are dropped when no cell is open: after reset, after a completed cell, or after a refused start.
- R5: `room_1` is 1 exactly when the effective depth exceeds (stored cells + 1 if a cell is being filled).
- R6: `room_2` is 1 exactly when the effective depth is at least (stored cells + cell being filled) + 2.
- R7: The effective depth is `depth_cells` clamped to the range 2 to 4: values 0 and 1 give 2, and values 5 to 7 give 4.
- R8: A start byte that arrives with no cell open and stored cells equal to the effective depth is dropped, together with the rest of its cell. `overflow_seen` then rises and stays 1 until reset.
- R9: Cells are read out in the order in which they completed. `out_soc` is 1 only on byte 0 of each cell, and a byte advances when `out_valid` and `out_ready` are both 1.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_soc` and `out_data` hold their values.
- R11: A slot becomes free in the cycle after the last byte of its cell is read, and the room outputs update accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_cells | input | 3 | Requested capacity in cells (clamped to 2..4) |
| in_valid | input | 1 | Byte transfer accepted this cycle |
| in_soc | input | 1 | Byte is the first of a cell |
| in_data | input | 8 | Cell byte |
| room_1 | output | 1 | At least one cell slot free |
| room_2 | output | 1 | At least two cell slots free |
| overflow_seen | output | 1 | Sticky: a start was refused for lack of space |
| out_valid | output | 1 | A stored cell byte is offered |
| out_soc | output | 1 | Offered byte is byte 0 of a cell |
| out_data | output | 8 | Offered byte |
| out_ready | input | 1 | Consumer takes the offered byte |

## Verification
The bench aims at the realignment case, where a fresh start marker lands after 20 bytes. A design that kept the stale bytes would read out a corrupted or shifted cell, or two cells instead of one. It holds a cell at 52 of 53 bytes to catch early release, and to catch room flags that ignore the slot being filled. It streams a cell with no start marker, which a design that does not hunt would store. It refuses a start on a full buffer, which exposes a lost sticky flag or a dropped cell that leaks into the buffer. It stalls the reader mid-cell, clamps out-of-range depths and frees slots one at a time. These steps catch unstable read data, a wrong depth decode and late slot release.

// File: rtl/ucb_pkg.sv
package ucb_pkg;

   typedef enum logic {
      WR_HUNT = 1'b0,
      WR_FILL = 1'b1
   } wr_state_e;

   // clamp a requested depth into the supported window
   function automatic int clamp_depth(input int req, input int lo, input int hi);
      if (req < lo) return lo;
      if (req > hi) return hi;
      return req;
   endfunction

endpackage

// File: rtl/ucb_occupancy.sv
module ucb_occupancy
   import ucb_pkg::*;
#(
   parameter int MAX_CELLS = 4,
   parameter int MIN_CELLS = 2,
   parameter int DEPTH_W   = 3,
   parameter int CNT_W     = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEPTH_W-1:0] depth_req,
   input  logic               commit,
   input  logic               rel_cell,
   input  logic               filling,
   output logic [CNT_W-1:0]   cell_cnt,
   output logic               can_open,
   output logic               room_1,
   output logic               room_2
);

   int eff_i;
   int cnt_i;
   int used_i;

   always_comb begin
      eff_i    = clamp_depth(int'(depth_req), MIN_CELLS, MAX_CELLS);
      cnt_i    = int'(cell_cnt);
      used_i   = cnt_i + (filling ? 1 : 0);
      can_open = cnt_i < eff_i;
      room_1   = used_i < eff_i;
      room_2   = (used_i + 2) <= eff_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cell_cnt <= '0;
      end else begin
         case ({commit, rel_cell})
            2'b10:   cell_cnt <= cell_cnt + CNT_W'(1);
            2'b01:   cell_cnt <= cell_cnt - CNT_W'(1);
            default: cell_cnt <= cell_cnt;
         endcase
      end
   end

   // R6
   room_two_implies_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      room_2 |-> room_1);

   // R11
   release_frees_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_cell && !commit) |=> (cell_cnt == $past(cell_cnt) - CNT_W'(1)));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_cnt <= CNT_W'(MAX_CELLS));

endmodule

// File: rtl/ucb_wr_assembler.sv
module ucb_wr_assembler
   import ucb_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int MAX_CELLS  = 4,
   parameter int IDX_W      = 6,
   parameter int PTR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_soc,
   input  logic [DATA_W-1:0] in_data,
   input  logic              can_open,
   output logic              mem_we,
   output logic [PTR_W-1:0]  mem_slot,
   output logic [IDX_W-1:0]  mem_idx,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              commit,
   output logic              filling,
   output logic              overflow
);

   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_BYTES - 1);
   localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(MAX_CELLS - 1);

   wr_state_e        st;
   logic [IDX_W-1:0] idx;
   logic [PTR_W-1:0] slot;
   logic [PTR_W-1:0] slot_nxt;
   logic             start_ok;
   logic             cont_ok;

   generate
      if ((1 << PTR_W) == MAX_CELLS) begin : g_wrap_pow2
         assign slot_nxt = slot + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign slot_nxt = (slot == LAST_SLOT) ? '0 : slot + PTR_W'(1);
      end
   endgenerate

   always_comb begin
      filling   = (st == WR_FILL);
      start_ok  = in_valid && in_soc && (filling || can_open);
      cont_ok   = in_valid && !in_soc && filling;
      mem_we    = start_ok || cont_ok;
      mem_slot  = slot;
      mem_idx   = in_soc ? '0 : idx;
      mem_wdata = in_data;
      commit    = cont_ok && (idx == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= WR_HUNT;
         idx      <= '0;
         slot     <= '0;
         overflow <= 1'b0;
      end else if (start_ok) begin
         st  <= WR_FILL;
         idx <= IDX_W'(1);
      end else if (in_valid && in_soc) begin
         st       <= WR_HUNT;
         overflow <= 1'b1;
      end else if (commit) begin
         st   <= WR_HUNT;
         idx  <= '0;
         slot <= slot_nxt;
      end else if (cont_ok) begin
         idx <= idx + IDX_W'(1);
      end
   end

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R3
   realign_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_soc && filling) |=> (filling && idx == IDX_W'(1) && $stable(slot)));

   // R4
   stray_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_soc && !filling) |-> !mem_we);

endmodule

// File: rtl/ucb_slot_store.sv
module ucb_slot_store #(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int MAX_CELLS  = 4,
   parameter int IDX_W      = 6,
   parameter int PTR_W      = 2
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  wr_slot,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_slot,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] bank_q [MAX_CELLS];

   generate
      for (genvar g = 0; g < MAX_CELLS; g++) begin : g_bank
         logic [DATA_W-1:0] bytes_q [CELL_BYTES];

         always_ff @(posedge clk) begin
            if (we && (wr_slot == PTR_W'(g))) begin
               bytes_q[wr_idx] <= wr_data;
            end
         end

         assign bank_q[g] = bytes_q[rd_idx];
      end
   endgenerate

   assign rd_data = bank_q[rd_slot];

endmodule

// File: rtl/ucb_rd_engine.sv
module ucb_rd_engine #(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int MAX_CELLS  = 4,
   parameter int IDX_W      = 6,
   parameter int PTR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cells_avail,
   input  logic              out_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [PTR_W-1:0]  rd_slot,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              rel_cell,
   output logic              out_valid,
   output logic              out_soc,
   output logic [DATA_W-1:0] out_data
);

   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_BYTES - 1);
   localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(MAX_CELLS - 1);

   logic [PTR_W-1:0] slot_nxt;
   logic             take;

   generate
      if ((1 << PTR_W) == MAX_CELLS) begin : g_wrap_pow2
         assign slot_nxt = rd_slot + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign slot_nxt = (rd_slot == LAST_SLOT) ? '0 : rd_slot + PTR_W'(1);
      end
   endgenerate

   always_comb begin
      out_valid = cells_avail;
      out_soc   = cells_avail && (rd_idx == '0);
      out_data  = mem_rdata;
      take      = out_valid && out_ready;
      rel_cell  = take && (rd_idx == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_slot <= '0;
         rd_idx  <= '0;
      end else if (rel_cell) begin
         rd_slot <= slot_nxt;
         rd_idx  <= '0;
      end else if (take) begin
         rd_idx <= rd_idx + IDX_W'(1);
      end
   end

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_soc)));

   // R9
   soc_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_cell |=> (!out_valid || out_soc));

endmodule

// File: rtl/utx_cell_buffer.sv
module utx_cell_buffer
   import ucb_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int MAX_CELLS  = 4,
   parameter int MIN_CELLS  = 2,
   parameter int DEPTH_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEPTH_W-1:0] depth_cells,
   input  logic               in_valid,
   input  logic               in_soc,
   input  logic [DATA_W-1:0]  in_data,
   output logic               room_1,
   output logic               room_2,
   output logic               overflow_seen,
   output logic               out_valid,
   output logic               out_soc,
   output logic [DATA_W-1:0]  out_data,
   input  logic               out_ready
);

   localparam int IDX_W = $clog2(CELL_BYTES);
   localparam int PTR_W = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1;
   localparam int CNT_W = $clog2(MAX_CELLS + 1);

   initial begin : param_chk
      assert (CELL_BYTES >= 2) else $error("CELL_BYTES must be at least 2");
      assert (MIN_CELLS >= 1 && MIN_CELLS <= MAX_CELLS) else $error("MIN_CELLS out of range");
      assert (MAX_CELLS < (1 << DEPTH_W)) else $error("DEPTH_W too narrow for MAX_CELLS");
   end

   logic               mem_we;
   logic [PTR_W-1:0]   mem_slot;
   logic [IDX_W-1:0]   mem_idx;
   logic [DATA_W-1:0]  mem_wdata;
   logic [DATA_W-1:0]  mem_rdata;
   logic [PTR_W-1:0]   rd_slot;
   logic [IDX_W-1:0]   rd_idx;
   logic               commit;
   logic               filling;
   logic               rel_cell;
   logic               can_open;
   logic [CNT_W-1:0]   cell_cnt;

   ucb_wr_assembler #(
      .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .MAX_CELLS(MAX_CELLS),
      .IDX_W(IDX_W), .PTR_W(PTR_W)
   ) wr_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data),
      .can_open(can_open),
      .mem_we(mem_we), .mem_slot(mem_slot), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
      .commit(commit), .filling(filling), .overflow(overflow_seen)
   );

   ucb_occupancy #(
      .MAX_CELLS(MAX_CELLS), .MIN_CELLS(MIN_CELLS), .DEPTH_W(DEPTH_W), .CNT_W(CNT_W)
   ) occ_i (
      .clk(clk), .rst_n(rst_n), .depth_req(depth_cells),
      .commit(commit), .rel_cell(rel_cell), .filling(filling),
      .cell_cnt(cell_cnt), .can_open(can_open), .room_1(room_1), .room_2(room_2)
   );

   ucb_slot_store #(
      .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .MAX_CELLS(MAX_CELLS),
      .IDX_W(IDX_W), .PTR_W(PTR_W)
   ) store_i (
      .clk(clk), .we(mem_we), .wr_slot(mem_slot), .wr_idx(mem_idx), .wr_data(mem_wdata),
      .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(mem_rdata)
   );

   ucb_rd_engine #(
      .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .MAX_CELLS(MAX_CELLS),
      .IDX_W(IDX_W), .PTR_W(PTR_W)
   ) rd_i (
      .clk(clk), .rst_n(rst_n), .cells_avail(cell_cnt != '0), .out_ready(out_ready),
      .mem_rdata(mem_rdata), .rd_slot(rd_slot), .rd_idx(rd_idx), .rel_cell(rel_cell),
      .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
   );

   // R2
   visible_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(commit));

endmodule

// File: tb/utx_cell_buffer_tb_top.sv
module utx_cell_buffer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCELL      = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] depth_cells = 3'd2;
   logic       in_valid = 1'b0;
   logic       in_soc = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       room_1, room_2, overflow_seen;
   logic       out_valid, out_soc;
   logic [7:0] out_data;
   logic       out_ready = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   utx_cell_buffer dut_i (
      .clk(clk), .rst_n(rst_n), .depth_cells(depth_cells),
      .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data),
      .room_1(room_1), .room_2(room_2), .overflow_seen(overflow_seen),
      .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data),
      .out_ready(out_ready)
   );

   typedef struct packed {
      logic [2:0] depth;
      logic [2:0] ncell;
      logic       r1;
      logic       r2;
      logic       ovf;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{3'd2, 3'd0, 1'b1, 1'b1, 1'b0},
      '{3'd2, 3'd1, 1'b1, 1'b0, 1'b0},
      '{3'd2, 3'd2, 1'b0, 1'b0, 1'b0},
      '{3'd2, 3'd3, 1'b0, 1'b0, 1'b1},
      '{3'd3, 3'd1, 1'b1, 1'b1, 1'b0},
      '{3'd3, 3'd2, 1'b1, 1'b0, 1'b0},
      '{3'd3, 3'd3, 1'b0, 1'b0, 1'b0},
      '{3'd4, 3'd2, 1'b1, 1'b1, 1'b0},
      '{3'd4, 3'd4, 1'b0, 1'b0, 1'b0},
      '{3'd4, 3'd5, 1'b0, 1'b0, 1'b1},
      '{3'd0, 3'd2, 1'b0, 1'b0, 1'b0},
      '{3'd7, 3'd3, 1'b1, 1'b0, 1'b0}
   };

   function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
      return seed + 8'(i * 3);
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; in_soc = 1'b0; out_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr_byte(input logic soc, input logic [7:0] d);
      @(negedge clk);
      in_valid = 1'b1; in_soc = soc; in_data = d;
   endtask

   task automatic wr_stop();
      @(negedge clk);
      in_valid = 1'b0; in_soc = 1'b0;
   endtask

   task automatic send_bytes(input logic [7:0] seed, input int n, input logic with_soc);
      for (int i = 0; i < n; i++) wr_byte(with_soc && (i == 0), pat(seed, i));
   endtask

   // reads bytes first..last-1 of the cell at the head, checking each one
   task automatic read_range(input string tag, input logic [7:0] seed, input int first, input int last);
      for (int i = first; i < last; i++) begin
         @(negedge clk);
         chk(tag, {out_valid, out_soc, out_data}, {1'b1, (i == 0), pat(seed, i)});
         out_ready = 1'b1;
      end
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin : main
      int eff;
      int stored;
      // R1: reset state
      do_reset();
      @(negedge clk);
      chk("R1 reset outputs", {out_valid, overflow_seen, room_1, room_2}, 4'b0011);

      // table walk: R5 R6 R7 R8 R9
      for (int v = 0; v < 12; v++) begin
         do_reset();
         depth_cells = VECS[v].depth;
         for (int c = 0; c < int'(VECS[v].ncell); c++)
            send_bytes(8'(v * 16 + c * 5 + 1), NCELL, 1'b1);
         wr_stop();
         chk("R5 R6 R7 R8 room/overflow", {room_1, room_2, overflow_seen},
             {VECS[v].r1, VECS[v].r2, VECS[v].ovf});
         eff = (VECS[v].depth < 2) ? 2 : (VECS[v].depth > 4) ? 4 : int'(VECS[v].depth);
         stored = (int'(VECS[v].ncell) < eff) ? int'(VECS[v].ncell) : eff;
         for (int c = 0; c < stored; c++)
            read_range("R9 cell order/content", 8'(v * 16 + c * 5 + 1), 0, NCELL);
         chk("R9 R8 no extra cell", {31'd0, out_valid}, 32'd0);
      end

      // R2 and R5: partial cell invisible but counted as occupying a slot
      do_reset();
      depth_cells = 3'd2;
      send_bytes(8'h40, NCELL - 1, 1'b1);
      wr_stop();
      chk("R2 52 bytes not visible", {31'd0, out_valid}, 32'd0);
      chk("R5 R6 in-progress slot counted", {30'd0, room_1, room_2}, 32'b10);
      wr_byte(1'b0, pat(8'h40, NCELL - 1));
      wr_stop();
      chk("R2 visible after last byte", {30'd0, out_valid, out_soc}, 32'b11);
      read_range("R2 cell content", 8'h40, 0, NCELL);

      // R3: early start marker discards partial cell
      send_bytes(8'h90, 20, 1'b1);
      send_bytes(8'h17, NCELL, 1'b1);
      wr_stop();
      read_range("R3 realigned cell", 8'h17, 0, NCELL);
      chk("R3 only one cell stored", {30'd0, out_valid, room_2}, 32'b01);

      // R4: stream without start marker is dropped
      send_bytes(8'h55, NCELL, 1'b0);
      wr_stop();
      chk("R4 stray bytes dropped", {29'd0, out_valid, room_1, room_2}, 32'b011);

      // R10: stall at byte 0 and mid-cell
      send_bytes(8'h23, NCELL, 1'b1);
      wr_stop();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R10 hold at byte 0", {out_valid, out_soc, out_data}, {1'b1, 1'b1, pat(8'h23, 0)});
      end
      read_range("R10 first bytes", 8'h23, 0, 5);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R10 hold mid-cell", {out_valid, out_soc, out_data}, {1'b1, 1'b0, pat(8'h23, 5)});
      end
      read_range("R10 remaining bytes", 8'h23, 5, NCELL);

      // R11 and R8: slots free one at a time, overflow stays set
      do_reset();
      depth_cells = 3'd2;
      send_bytes(8'h61, NCELL, 1'b1);
      send_bytes(8'h72, NCELL, 1'b1);
      send_bytes(8'h83, NCELL, 1'b1);
      wr_stop();
      chk("R8 full and overflow", {room_1, room_2, overflow_seen}, 3'b001);
      read_range("R11 first cell", 8'h61, 0, NCELL);
      chk("R11 one slot freed", {room_1, room_2, overflow_seen}, 3'b101);
      read_range("R11 second cell", 8'h72, 0, NCELL);
      chk("R11 R8 all freed, sticky", {out_valid, room_1, room_2, overflow_seen}, 4'b0111);

      done = 1'b1;
      summary();
   end

endmodule